// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses for one burst access to a burst-oriented DRAM. When the command path pulses `start_i`, the block captures three things: the start column, a coded burst length and a burst-order bit. It then emits two column addresses per clock, an even beat and an odd beat, until every beat of the burst has been addressed. The beats follow either a wrapping sequential order or an interleaved order.

The block also produces a data-valid window that trails the start by the programmed CAS latency, which is 2 or 3 cycles. This lines the window up with the read data returned for those beats.

If the configuration holds a reserved length or latency code, the block refuses the start and raises a sticky error flag. The next accepted start clears that flag.

Top module: `burst_col_seq`

## Requirements
- R1: Burst-length codes decode as 3'b001 to 2 beats, 3'b010 to 4, 3'b011 to 8 and 3'b100 to 16. Latency codes decode as 3'b010 to 2 cycles and 3'b011 to 3 cycles. Every other code is reserved.
- R2: With `bt_i`=0 (sequential), the low log2(BL) bits of beat i equal (start + i) mod BL. All higher column bits equal those of the start column.
- R3: With `bt_i`=1 (interleaved), the low log2(BL) bits of beat i equal the start's low bits XOR i. All higher column bits equal those of the start column.
- R4: A start is accepted at a clock edge where it is sampled high, no burst is running and both codes are legal. In the j-th cycle after that edge (j = 0 .. BL/2-1), `addr_vld_o` is high, `col_even_o` carries beat 2j and `col_odd_o` carries beat 2j+1. Column, length and order are taken only at the accepting edge.
- R5: `data_vld_o` goes high CL clock edges after the accepting edge and stays high for exactly BL/2 cycles. It uses the latency captured at acceptance.
- R6: A start sampled while idle with any reserved code is refused, so no address phase follows. `err_o` is high from the next cycle and stays high until a later start is accepted, which clears it.
- R7: A start sampled while an address phase is running is ignored and does not change `err_o`.
- R8: While `rst_ni` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Burst launch strobe |
| col_i | input | COL_W | Start column |
| bl_code_i | input | 3 | Burst-length code |
| bt_i | input | 1 | Burst order: 0 sequential, 1 interleaved |
| cl_code_i | input | 3 | CAS latency code |
| col_even_o | output | COL_W | Column of the even beat in this cycle |
| col_odd_o | output | COL_W | Column of the odd beat in this cycle |
| addr_vld_o | output | 1 | Column outputs are valid |
| data_vld_o | output | 1 | Data window, delayed by CAS latency |
| err_o | output | 1 | Sticky flag for a refused start |

## Verification
The data window of one burst and the address phase of the next can fall in the same cycle. This happens when a latency-3 burst is followed at once by a latency-2 burst, or by any burst started on the first idle edge.

The bench provokes this by holding `start_i` high through a running burst with a new configuration. The held strobe is ignored while the burst runs and is accepted on the first idle edge. A cycle-level reference model tracks each burst's data window on its own. Every cycle, the bench compares both column lanes, the address-valid output and the data-valid output against that model, so a window that is cut short, stretched or shifted by the overlap shows up as a mismatch.

// File: rtl/burst_col_seq_pkg.sv
package burst_col_seq_pkg;

  localparam int CL_W = 2;

  // returns log2(BL), 0 for reserved codes
  function automatic logic [2:0] bl_code_log2(input logic [2:0] code);
    case (code)
      3'b001:  return 3'd1;
      3'b010:  return 3'd2;
      3'b011:  return 3'd3;
      3'b100:  return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  // returns latency in cycles, 0 for reserved codes
  function automatic logic [CL_W-1:0] cl_code_cycles(input logic [2:0] code);
    case (code)
      3'b010:  return CL_W'(2);
      3'b011:  return CL_W'(3);
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/bcs_cfg_dec.sv
module bcs_cfg_dec
  import burst_col_seq_pkg::*;
#(
  parameter int MAX_LOG2 = 4
) (
  input  logic [2:0]      bl_code_i,
  input  logic [2:0]      cl_code_i,
  output logic            legal_o,
  output logic [2:0]      len_log2_o,
  output logic [CL_W-1:0] cl_o
);
  always_comb begin
    len_log2_o = bl_code_log2(bl_code_i);
    cl_o       = cl_code_cycles(cl_code_i);
    legal_o    = (len_log2_o != 3'd0) && (int'(len_log2_o) <= MAX_LOG2) && (cl_o != '0);
  end
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen #(
  parameter int COL_W    = 10,
  parameter int MAX_LOG2 = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [COL_W-1:0] base_i,
  input  logic [2:0]       len_log2_i,
  input  logic             bt_i,
  output logic             active_o,
  output logic [COL_W-1:0] col_even_o,
  output logic [COL_W-1:0] col_odd_o
);
  localparam int CNT_W = (MAX_LOG2 > 1) ? MAX_LOG2 - 1 : 1;
  localparam int LANES = 2;

  logic             active_q;
  logic [CNT_W-1:0] cnt_q, last_q;
  logic [COL_W-1:0] base_q, mask_q;
  logic             bt_q;
  logic [COL_W-1:0] lane_col [LANES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      last_q   <= '0;
      base_q   <= '0;
      mask_q   <= '0;
      bt_q     <= 1'b0;
    end else if (load_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      // BL/2 - 1 cycles after the first
      last_q   <= (CNT_W'(1) << (len_log2_i - 3'd1)) - CNT_W'(1);
      mask_q   <= ~({COL_W{1'b1}} << len_log2_i);
      base_q   <= base_i;
      bt_q     <= bt_i;
    end else if (active_q) begin
      if (cnt_q == last_q) active_q <= 1'b0;
      else                 cnt_q    <= cnt_q + CNT_W'(1);
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [COL_W-1:0] idx, low;
    assign idx = COL_W'({cnt_q, 1'(l)});
    assign low = (bt_q ? (base_q ^ idx) : (base_q + idx)) & mask_q;
    assign lane_col[l] = (base_q & ~mask_q) | low;
  end

  assign active_o   = active_q;
  assign col_even_o = lane_col[0];
  assign col_odd_o  = lane_col[1];
endmodule

// File: rtl/bcs_vld_dly.sv
module bcs_vld_dly
  import burst_col_seq_pkg::*;
#(
  parameter int MAX_CL = 3,
  parameter int MIN_CL = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            vld_i,
  input  logic [CL_W-1:0] cl_i,
  output logic            vld_o
);
  // each stage carries its own latency tag so windows of adjacent bursts stay apart
  logic            v_q [1:MAX_CL];
  logic [CL_W-1:0] c_q [1:MAX_CL];
  logic [MAX_CL:MIN_CL] hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 1; i <= MAX_CL; i++) begin
        v_q[i] <= 1'b0;
        c_q[i] <= '0;
      end
    end else begin
      v_q[1] <= vld_i;
      c_q[1] <= cl_i;
      for (int i = 2; i <= MAX_CL; i++) begin
        v_q[i] <= v_q[i-1];
        c_q[i] <= c_q[i-1];
      end
    end
  end

  for (genvar d = MIN_CL; d <= MAX_CL; d++) begin : g_tap
    assign hit[d] = v_q[d] && (c_q[d] == CL_W'(d));
  end

  assign vld_o = |hit;
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_col_seq_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int MAX_BL = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [2:0]       bl_code_i,
  input  logic             bt_i,
  input  logic [2:0]       cl_code_i,
  output logic [COL_W-1:0] col_even_o,
  output logic [COL_W-1:0] col_odd_o,
  output logic             addr_vld_o,
  output logic             data_vld_o,
  output logic             err_o
);
  localparam int MAX_LOG2 = $clog2(MAX_BL);

  logic            legal, active, accept, refuse;
  logic [2:0]      len_log2;
  logic [CL_W-1:0] cl_val, cl_q;
  logic            err_q;

  bcs_cfg_dec #(.MAX_LOG2(MAX_LOG2)) u_dec (
    .bl_code_i  (bl_code_i),
    .cl_code_i  (cl_code_i),
    .legal_o    (legal),
    .len_log2_o (len_log2),
    .cl_o       (cl_val)
  );

  assign accept = start_i & ~active & legal;
  assign refuse = start_i & ~active & ~legal;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cl_q  <= '0;
      err_q <= 1'b0;
    end else if (accept) begin
      cl_q  <= cl_val;
      err_q <= 1'b0;
    end else if (refuse) begin
      err_q <= 1'b1;
    end
  end

  bcs_addr_gen #(.COL_W(COL_W), .MAX_LOG2(MAX_LOG2)) u_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .base_i     (col_i),
    .len_log2_i (len_log2),
    .bt_i       (bt_i),
    .active_o   (active),
    .col_even_o (col_even_o),
    .col_odd_o  (col_odd_o)
  );

  bcs_vld_dly #(.MAX_CL(3), .MIN_CL(2)) u_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (active),
    .cl_i   (cl_q),
    .vld_o  (data_vld_o)
  );

  assign addr_vld_o = active;
  assign err_o      = err_q;
endmodule

// File: rtl/bcs_chk.sv
module bcs_chk #(
  parameter int COL_W  = 10,
  parameter int MAX_BL = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [COL_W-1:0] col_even_o,
  input logic [COL_W-1:0] col_odd_o,
  input logic             addr_vld_o,
  input logic             data_vld_o,
  input logic             err_o
);
  localparam int RUN_W = $clog2(MAX_BL) + 1;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         run_q <= '0;
    else if (addr_vld_o) run_q <= run_q + RUN_W'(1);
    else                 run_q <= '0;
  end

  AST_RUN_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(run_q) <= MAX_BL / 2); // R4

  AST_LANE_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_vld_o |-> ((col_even_o ^ col_odd_o) < COL_W'(MAX_BL))); // R4

  AST_UPPER_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_vld_o && $past(addr_vld_o)) |-> ((col_even_o ^ $past(col_even_o)) < COL_W'(MAX_BL))); // R2

  AST_DATA_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_vld_o) |-> ($past(addr_vld_o, 2) || $past(addr_vld_o, 3))); // R5

  AST_ERR_NO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !addr_vld_o); // R6

  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(err_o) && !addr_vld_o) |-> err_o); // R6
endmodule

bind burst_col_seq bcs_chk #(.COL_W(COL_W), .MAX_BL(MAX_BL)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .col_even_o (col_even_o),
  .col_odd_o  (col_odd_o),
  .addr_vld_o (addr_vld_o),
  .data_vld_o (data_vld_o),
  .err_o      (err_o)
);

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;
  localparam int COL_W = 10;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] col_i = '0;
  logic [2:0]       bl_code_i = 3'b001;
  logic             bt_i = 1'b0;
  logic [2:0]       cl_code_i = 3'b010;
  logic [COL_W-1:0] col_even_o, col_odd_o;
  logic             addr_vld_o, data_vld_o, err_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  burst_col_seq #(.COL_W(COL_W), .MAX_BL(16)) u_dut (.*);

  // R1 decode, from the requirement
  function automatic int bl_dec(logic [2:0] c);
    case (c) 3'b001: return 2; 3'b010: return 4; 3'b011: return 8; 3'b100: return 16; default: return 0; endcase
  endfunction
  function automatic int cl_dec(logic [2:0] c);
    case (c) 3'b010: return 2; 3'b011: return 3; default: return 0; endcase
  endfunction
  function automatic logic [COL_W-1:0] exp_col(logic [COL_W-1:0] base, int bl, bit bt, int i);
    logic [COL_W-1:0] mask, low;
    mask = COL_W'(bl - 1);
    low  = bt ? ((base ^ COL_W'(i)) & mask) : ((base + COL_W'(i)) & mask); // R3 / R2
    return (base & ~mask) | low;
  endfunction

  // reference model, state after the latest edge
  int cyc = 0;
  bit m_act = 0, m_bt = 0, m_err = 0;
  int m_cnt = 0, m_bl = 0;
  logic [COL_W-1:0] m_base = '0;
  int w_lo [2] = '{-100, -100};
  int w_hi [2] = '{-200, -200};
  int wi = 0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_act = 0; m_err = 0; m_cnt = 0;
      w_lo = '{-100, -100}; w_hi = '{-200, -200};
    end else begin
      bit go;
      cyc++;
      go = start_i && !m_act;
      if (m_act) begin
        if (m_cnt == m_bl / 2 - 1) m_act = 0;
        else m_cnt++;
      end
      if (go && bl_dec(bl_code_i) != 0 && cl_dec(cl_code_i) != 0) begin
        m_act = 1; m_cnt = 0; m_bl = bl_dec(bl_code_i);
        m_base = col_i; m_bt = bt_i; m_err = 0;
        w_lo[wi] = cyc + cl_dec(cl_code_i);
        w_hi[wi] = cyc + cl_dec(cl_code_i) + m_bl / 2 - 1;
        wi ^= 1;
      end else if (go) begin
        m_err = 1;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s cyc=%0d %s act=%0h exp=%0h", req, cyc, what, act, exp);
    end
  endtask

  // compare every cycle away from the active edge
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      chk(!addr_vld_o && !data_vld_o && !err_o && col_even_o == '0 && col_odd_o == '0,
          "R8", "reset outputs", {addr_vld_o, data_vld_o, err_o}, 0);
    end else if (!done) begin
      bit dv;
      dv = (cyc >= w_lo[0] && cyc <= w_hi[0]) || (cyc >= w_lo[1] && cyc <= w_hi[1]);
      chk(addr_vld_o == m_act, "R1 R4 R7", "addr_vld", addr_vld_o, m_act);
      chk(data_vld_o == dv, "R5", "data_vld", data_vld_o, dv);
      chk(err_o == m_err, "R6", "err", err_o, m_err);
      if (m_act) begin
        logic [COL_W-1:0] e0, e1;
        e0 = exp_col(m_base, m_bl, m_bt, 2 * m_cnt);
        e1 = exp_col(m_base, m_bl, m_bt, 2 * m_cnt + 1);
        chk(col_even_o == e0, m_bt ? "R3 R4" : "R2 R4", "col_even", col_even_o, e0);
        chk(col_odd_o == e1, m_bt ? "R3 R4" : "R2 R4", "col_odd", col_odd_o, e1);
      end
    end
  end

  task automatic scramble_cfg();
    bl_code_i = 3'($urandom);
    bt_i      = 1'($urandom);
    cl_code_i = 3'($urandom);
    col_i     = COL_W'($urandom);
  endtask

  task automatic launch(logic [2:0] bc, bit bt, logic [2:0] cc, logic [COL_W-1:0] col);
    @(negedge clk_i);
    bl_code_i = bc; bt_i = bt; cl_code_i = cc; col_i = col; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    scramble_cfg(); // R4: config is captured only at acceptance
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // every start column, every length, both orders
    for (int bc = 1; bc <= 4; bc++) begin
      for (int bt = 0; bt < 2; bt++) begin
        for (int s = 0; s < bl_dec(3'(bc)); s++) begin
          logic [COL_W-1:0] col;
          col = (COL_W'($urandom) & ~COL_W'(bl_dec(3'(bc)) - 1)) | COL_W'(s);
          launch(3'(bc), 1'(bt), 3'b010 + 3'($urandom % 2), col);
          repeat (bl_dec(3'(bc)) / 2 + 4) @(negedge clk_i);
        end
      end
    end

    // R7 and overlap: held start during a CL3 burst, accepted on first idle edge with CL2
    @(negedge clk_i);
    bl_code_i = 3'b011; bt_i = 1'b0; cl_code_i = 3'b011; col_i = 10'h3F5; start_i = 1'b1;
    @(negedge clk_i);
    bl_code_i = 3'b010; bt_i = 1'b1; cl_code_i = 3'b010; col_i = 10'h1A2;
    repeat (9) @(negedge clk_i);
    start_i = 1'b0;
    repeat (8) @(negedge clk_i);

    // R6: each reserved code refused, then cleared by a legal start
    for (int c = 0; c < 8; c++) begin
      if (bl_dec(3'(c)) == 0) begin
        launch(3'(c), 1'b0, 3'b010, 10'h010);
        repeat (3) @(negedge clk_i);
      end
      if (cl_dec(3'(c)) == 0) begin
        launch(3'b010, 1'b1, 3'(c), 10'h020);
        repeat (3) @(negedge clk_i);
      end
      launch(3'b001, 1'b0, 3'b011, 10'h033);
      repeat (5) @(negedge clk_i);
    end

    // random phase with reserved codes and starts that land mid-burst
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk_i);
      start_i = ($urandom % 3) == 0;
      bl_code_i = ($urandom % 8 == 0) ? 3'($urandom) : 3'(1 + $urandom % 4);
      cl_code_i = ($urandom % 8 == 0) ? 3'($urandom) : 3'(2 + $urandom % 2);
      bt_i = 1'($urandom);
      col_i = COL_W'($urandom);
    end
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (10) @(negedge clk_i);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule